// File: doc/BRIEF.md
# Principal component projection unit

This block turns a stored matrix of centred data vectors into principal-component scores. Local memory already holds the difference matrix D, which has n rows of m signed values, each row being one data vector minus the per-dimension mean. Memory also holds the m×m eigenvector matrix S. For every output element the block forms the dot product of one row of D with one column of S: Z[i][j] = sum over k of D[i][k]·S[k][j]. It writes the n×m score matrix back through a result port.

Software sets the dimension count m and the vector count n on the inputs and pulses `start`. The unit takes those values in, runs to the end and then pulses `done`. Both read ports are issued together, one operand pair per cycle. The data for a read returns one cycle after the read is issued. Products are summed in a wide accumulator, and each score is clamped to the signed output range before it is written.

Top module: `pc_project`

## Requirements
- R1: Each result equals the exact signed sum over k = 0..m-1 of D[i*m+k]·S[k*m+j], where operands are signed 16-bit two's complement values, whenever that sum fits in a signed 32-bit value.
- R2: Exactly m·n results are written. They come with i in the outer loop and j in the inner loop, and result (i,j) is written at address i*m+j.
- R3: A sum above 2147483647 is written as 0x7FFFFFFF, and a sum below -2147483648 is written as 0x80000000.
- R4: The difference matrix is read at address i*m+k and the eigenvector matrix at address k*m+j. Both reads are issued in the same cycle, one pair per cycle, and read data is expected one cycle after its read. With `start` sampled at clock edge 0, `done` is high in cycle m·m·n+4.
- R5: `done` is a single-cycle pulse in the cycle after the final result write. `busy` is high from the cycle after an accepted start up to and including the final write cycle.
- R6: A `start` that arrives while `busy` is high is ignored. The m and n values captured at the accepted start govern the whole run, even if the inputs change afterwards.
- R7: A start with m = 0 or n = 0 issues no reads and no writes, and it pulses `done` in the next cycle.
- R8: After reset, `busy`, `done`, the read enables and the write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when idle |
| dim_m | input | 4 | Dimension count m (0..MAX_DIM) |
| num_n | input | 7 | Vector count n (0..MAX_VEC) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| diff_rd_en | output | 1 | Difference-matrix read strobe |
| diff_rd_addr | output | 9 | Difference-matrix address, i*m+k |
| diff_rd_data | input | 16 | Difference-matrix data, one cycle after read |
| eig_rd_en | output | 1 | Eigenvector-matrix read strobe |
| eig_rd_addr | output | 6 | Eigenvector-matrix address, k*m+j |
| eig_rd_data | input | 16 | Eigenvector-matrix data, one cycle after read |
| res_wr_en | output | 1 | Result write strobe |
| res_wr_addr | output | 9 | Result address, i*m+j |
| res_wr_data | output | 32 | Saturated score |

## Verification
Random full-range operands at several sizes, from 1×1 up to the largest m and n, check the sums and the accumulator clearing between back-to-back elements. A permutation eigenvector matrix makes each score equal to one shifted element of D, so a swapped row/column index or a wrong stride produces a visibly wrong value. Operands held at the extreme values drive the sums past both output limits, and a 2-dimensional case lands just one count past the positive limit. Zero-sized runs and a run that is poked with a new start and new dimensions part way through show that zero sizes and mid-run inputs are handled as required.

// File: rtl/pc_proj_pkg.sv
// Shared definitions for the principal component projection unit.
// Assumes nothing beyond IEEE 1800-2017.
package pc_proj_pkg;
    localparam int DEF_DW      = 16;
    localparam int DEF_ACC_W   = 40;
    localparam int DEF_OUT_W   = 32;
    localparam int DEF_MAX_DIM = 8;
    localparam int DEF_MAX_VEC = 64;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pc_proj_seq.sv
// Operand sequencer: walks i (outer), j, k (inner) and issues one read pair
// per cycle. It tags each pair with first/last-of-element, final-of-run and
// the result address. It assumes m_in is in 1..MAX_DIM and n_in is in
// 1..MAX_VEC when go is pulsed.
module pc_proj_seq
    import pc_proj_pkg::*;
#(
    parameter int MAX_DIM = DEF_MAX_DIM,
    parameter int MAX_VEC = DEF_MAX_VEC,
    localparam int DIM_W   = $clog2(MAX_DIM + 1),
    localparam int VEC_W   = $clog2(MAX_VEC + 1),
    localparam int DADDR_W = $clog2(MAX_DIM * MAX_VEC),
    localparam int EADDR_W = $clog2(MAX_DIM * MAX_DIM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [DIM_W-1:0]   m_in,
    input  logic [VEC_W-1:0]   n_in,
    output logic               issue,
    output logic [DADDR_W-1:0] diff_addr,
    output logic [EADDR_W-1:0] eig_addr,
    output logic               tag_first,
    output logic               tag_last,
    output logic               tag_final,
    output logic [DADDR_W-1:0] tag_addr
);
    seq_state_t         state;
    logic [DIM_W-1:0]   m_q, j_q, k_q;
    logic [VEC_W-1:0]   n_q, i_q;
    logic [DADDR_W-1:0] row_base;
    logic [EADDR_W-1:0] k_off;
    logic               k_last, j_last, i_last;

    // End-of-loop detection for each counter.
    always_comb begin
        k_last = (k_q == m_q - DIM_W'(1));
        j_last = (j_q == m_q - DIM_W'(1));
        i_last = (i_q == n_q - VEC_W'(1));
    end

    // Read addresses and tags for the pair being issued.
    always_comb begin
        issue     = (state == SQ_RUN);
        diff_addr = row_base + DADDR_W'(k_q);
        eig_addr  = k_off + EADDR_W'(j_q);
        tag_first = (k_q == '0);
        tag_last  = k_last;
        tag_final = k_last && j_last && i_last;
        tag_addr  = row_base + DADDR_W'(j_q);
    end

    // Loop counters and running address bases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            m_q      <= '0;
            n_q      <= '0;
            i_q      <= '0;
            j_q      <= '0;
            k_q      <= '0;
            row_base <= '0;
            k_off    <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        state    <= SQ_RUN;
                        m_q      <= m_in;
                        n_q      <= n_in;
                        i_q      <= '0;
                        j_q      <= '0;
                        k_q      <= '0;
                        row_base <= '0;
                        k_off    <= '0;
                    end
                end
                SQ_RUN: begin
                    if (!k_last) begin
                        k_q   <= k_q + DIM_W'(1);
                        k_off <= k_off + EADDR_W'(m_q);
                    end else begin
                        k_q   <= '0;
                        k_off <= '0;
                        if (!j_last) begin
                            j_q <= j_q + DIM_W'(1);
                        end else begin
                            j_q <= '0;
                            if (!i_last) begin
                                i_q      <= i_q + VEC_W'(1);
                                row_base <= row_base + DADDR_W'(m_q);
                            end else begin
                                state <= SQ_IDLE;
                            end
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pc_proj_mac.sv
// Pipelined multiply-accumulate. Stage 1 aligns the tags with the read data,
// which arrives one cycle after the read. Stage 2 registers the product.
// Stage 3 accumulates, clearing on the first term of an element, and on the
// last term registers a saturated result write.
module pc_proj_mac
    import pc_proj_pkg::*;
#(
    parameter int DW     = DEF_DW,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int OUT_W  = DEF_OUT_W,
    parameter int ADDR_W = 9,
    localparam int PROD_W = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_final,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DW-1:0]     op_a,
    input  logic [DW-1:0]     op_b,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [OUT_W-1:0]  wr_data,
    output logic              wr_final
);
    localparam logic signed [ACC_W-1:0] SAT_HI =
        {{(ACC_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO =
        {{(ACC_W - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

    logic                     v1, f1, l1, x1;
    logic [ADDR_W-1:0]        a1;
    logic                     v2, f2, l2, x2;
    logic [ADDR_W-1:0]        a2;
    logic signed [PROD_W-1:0] prod_c, prod_q;
    logic signed [ACC_W-1:0]  acc_q, acc_next, prod_ext;
    logic [OUT_W-1:0]         sat_val;

    // Signed product of the operand pair that has just returned from memory.
    always_comb prod_c = $signed(op_a) * $signed(op_b);

    // Next accumulator value and its clamped output form.
    always_comb begin
        prod_ext = {{(ACC_W - PROD_W){prod_q[PROD_W-1]}}, prod_q};
        acc_next = f2 ? prod_ext : acc_q + prod_ext;
        if (acc_next > SAT_HI)
            sat_val = SAT_HI[OUT_W-1:0];
        else if (acc_next < SAT_LO)
            sat_val = SAT_LO[OUT_W-1:0];
        else
            sat_val = acc_next[OUT_W-1:0];
    end

    // Stage 1: delay the tags by the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0; x1 <= 1'b0; a1 <= '0;
        end else begin
            v1 <= in_valid;
            f1 <= in_first;
            l1 <= in_last;
            x1 <= in_final;
            a1 <= in_addr;
        end
    end

    // Stage 2: register the product with its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0; x2 <= 1'b0; a2 <= '0;
            prod_q <= '0;
        end else begin
            v2     <= v1;
            f2     <= f1;
            l2     <= l1;
            x2     <= x1;
            a2     <= a1;
            prod_q <= prod_c;
        end
    end

    // Stage 3: accumulate and emit the result on the last term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_final <= 1'b0;
        end else begin
            wr_en    <= v2 && l2;
            wr_final <= v2 && l2 && x2;
            if (v2) begin
                acc_q <= acc_next;
            end
            if (v2 && l2) begin
                wr_addr <= a2;
                wr_data <= sat_val;
            end
        end
    end
endmodule

// File: rtl/pc_project.sv
// Principal component projection top. It accepts start only when idle,
// treats a zero m or n as an empty run, and otherwise drives the sequencer
// and the MAC pipeline. It keeps busy high until the final write and then
// pulses done. It assumes both memories return read data one cycle after
// a read.
module pc_project
    import pc_proj_pkg::*;
#(
    parameter int DW      = DEF_DW,
    parameter int ACC_W   = DEF_ACC_W,
    parameter int OUT_W   = DEF_OUT_W,
    parameter int MAX_DIM = DEF_MAX_DIM,
    parameter int MAX_VEC = DEF_MAX_VEC,
    localparam int DIM_W   = $clog2(MAX_DIM + 1),
    localparam int VEC_W   = $clog2(MAX_VEC + 1),
    localparam int DADDR_W = $clog2(MAX_DIM * MAX_VEC),
    localparam int EADDR_W = $clog2(MAX_DIM * MAX_DIM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DIM_W-1:0]   dim_m,
    input  logic [VEC_W-1:0]   num_n,
    output logic               busy,
    output logic               done,
    output logic               diff_rd_en,
    output logic [DADDR_W-1:0] diff_rd_addr,
    input  logic [DW-1:0]      diff_rd_data,
    output logic               eig_rd_en,
    output logic [EADDR_W-1:0] eig_rd_addr,
    input  logic [DW-1:0]      eig_rd_data,
    output logic               res_wr_en,
    output logic [DADDR_W-1:0] res_wr_addr,
    output logic [OUT_W-1:0]   res_wr_data
);
    logic               accept, empty_run, go;
    logic               issue, t_first, t_last, t_final, wr_final;
    logic [DADDR_W-1:0] t_addr;
    logic               busy_q, done_q;

    // Start qualification: idle-only, zero sizes short-circuit.
    always_comb begin
        accept    = start && !busy_q;
        empty_run = (dim_m == '0) || (num_n == '0);
        go        = accept && !empty_run;
    end

    pc_proj_seq #(
        .MAX_DIM (MAX_DIM),
        .MAX_VEC (MAX_VEC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .m_in      (dim_m),
        .n_in      (num_n),
        .issue     (issue),
        .diff_addr (diff_rd_addr),
        .eig_addr  (eig_rd_addr),
        .tag_first (t_first),
        .tag_last  (t_last),
        .tag_final (t_final),
        .tag_addr  (t_addr)
    );

    pc_proj_mac #(
        .DW     (DW),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .ADDR_W (DADDR_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (issue),
        .in_first (t_first),
        .in_last  (t_last),
        .in_final (t_final),
        .in_addr  (t_addr),
        .op_a     (diff_rd_data),
        .op_b     (eig_rd_data),
        .wr_en    (res_wr_en),
        .wr_addr  (res_wr_addr),
        .wr_data  (res_wr_data),
        .wr_final (wr_final)
    );

    // Both memories are read in lockstep.
    always_comb begin
        diff_rd_en = issue;
        eig_rd_en  = issue;
    end

    // Run flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (res_wr_en && wr_final) || (accept && empty_run);
            if (go)
                busy_q <= 1'b1;
            else if (res_wr_en && wr_final)
                busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/pc_project_chk.sv
// Protocol checker for pc_project, attached by bind. Observes handshake,
// read and write strobes only.
module pc_project_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic diff_rd_en,
    input logic eig_rd_en,
    input logic res_wr_en
);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_write_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |-> busy);

    p_read_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        diff_rd_en |-> (eig_rd_en && busy));

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !res_wr_en) |=> busy);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pc_project pc_project_chk u_chk (.*);

// File: tb/pc_project_tb.sv
// Scoreboard bench: each job fills the memories, pushes the expected writes
// into queues and starts the run. A monitor pops and compares every write.
module pc_project_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  dim_m = '0;
    logic [6:0]  num_n = '0;
    logic        busy, done;
    logic        diff_rd_en, eig_rd_en, res_wr_en;
    logic [8:0]  diff_rd_addr, res_wr_addr;
    logic [5:0]  eig_rd_addr;
    logic [15:0] diff_rd_data, eig_rd_data;
    logic [31:0] res_wr_data;

    logic signed [15:0] dmem [0:511];
    logic signed [15:0] emem [0:63];

    int checks = 0;
    int fails  = 0;
    int exp_addr [$];
    int exp_data [$];
    string cur_req = "R1";
    bit [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pc_project u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dim_m(dim_m), .num_n(num_n),
        .busy(busy), .done(done),
        .diff_rd_en(diff_rd_en), .diff_rd_addr(diff_rd_addr), .diff_rd_data(diff_rd_data),
        .eig_rd_en(eig_rd_en), .eig_rd_addr(eig_rd_addr), .eig_rd_data(eig_rd_data),
        .res_wr_en(res_wr_en), .res_wr_addr(res_wr_addr), .res_wr_data(res_wr_data)
    );

    // Memory models with one-cycle read latency.
    always @(posedge clk) begin
        if (diff_rd_en) diff_rd_data <= dmem[diff_rd_addr];
        if (eig_rd_en)  eig_rd_data  <= emem[eig_rd_addr];
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    // Monitor: compare every write with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_wr_en) begin
            if (exp_addr.size() == 0) begin
                chk("R2 extra write", 1, 0);
            end else begin
                chk("R2 address", longint'(res_wr_addr), longint'(exp_addr.pop_front()));
                chk(cur_req, longint'($signed(res_wr_data)), longint'(exp_data.pop_front()));
            end
        end
    end

    // mode 0 random, 1 random D with permuted S, 2 max-positive, 3 max-negative.
    task automatic run_job(input int m, input int n, input int mode,
                           input string req, input bit poke);
        int cyc;
        cur_req = req;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < m; k++)
                dmem[i*m+k] = (mode >= 2) ? 16'sh8000 : $signed(rnd16());
        for (int k = 0; k < m; k++)
            for (int j = 0; j < m; j++)
                case (mode)
                    1:       emem[k*m+j] = (k == (j + 1) % m) ? 16'sd1 : 16'sd0;
                    2:       emem[k*m+j] = 16'sh8000;
                    3:       emem[k*m+j] = 16'sh7FFF;
                    default: emem[k*m+j] = $signed(rnd16());
                endcase
        for (int i = 0; i < n; i++)
            for (int j = 0; j < m; j++) begin
                longint s = 0;
                for (int k = 0; k < m; k++)
                    s += longint'(dmem[i*m+k]) * longint'(emem[k*m+j]);
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
                exp_addr.push_back(i*m+j);
                exp_data.push_back(int'(s));
            end
        @(negedge clk);
        start = 1'b1;
        dim_m = 4'(m);
        num_n = 7'(n);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            if (poke) begin
                start = (cyc == 5);
                if (cyc == 5) begin
                    dim_m = 4'(m + 1);
                    num_n = 7'(n + 2);
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R4 done latency", cyc, (m == 0 || n == 0) ? 1 : m*m*n + 4);
        chk("R5 busy low with done", longint'(busy), 0);
        @(negedge clk);
        chk("R5 done single pulse", longint'(done), 0);
        chk(poke ? "R6 write count" : "R2 write count", exp_addr.size(), 0);
        exp_addr.delete();
        exp_data.delete();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 busy", longint'(busy), 0);
        chk("R8 done", longint'(done), 0);
        chk("R8 read enable", longint'(diff_rd_en | eig_rd_en), 0);
        chk("R8 write enable", longint'(res_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_job(3, 4, 0, "R1", 1'b0);
        run_job(1, 1, 0, "R1", 1'b0);
        run_job(4, 3, 1, "R1 R4 permutation", 1'b0);
        run_job(8, 5, 0, "R1", 1'b0);
        run_job(8, 2, 2, "R3 positive", 1'b0);
        run_job(8, 2, 3, "R3 negative", 1'b0);
        run_job(2, 3, 2, "R3 edge", 1'b0);
        run_job(3, 4, 0, "R6", 1'b1);
        run_job(0, 3, 0, "R7", 1'b0);
        run_job(5, 0, 0, "R7", 1'b0);
        run_job(8, 64, 0, "R1", 1'b0);
        report();
    end
endmodule